// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block is a multi-cycle arithmetic unit that sits beside an integer pipeline. It multiplies or divides two W-bit operands, signed or unsigned, one bit per clock. It keeps its results in a pair of W-bit result registers, HI and LO, which stay readable at all times. A multiply fills HI:LO with the full double-width product, so LO is also the low half of the product. A divide puts the remainder in HI and the quotient in LO. Both are read by later move-from operations through the `hi` and `lo` ports.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole time an operation runs, so a request offered then is not taken. The requester must hold its operands until it sees `req_ready`. The unit never stalls its result: `done` is a single-cycle strobe with no ready of its own, and HI/LO keep the value until the next completion.

Signed operations run on magnitudes. The sign is applied in one extra cycle at the end. The unit raises no overflow or divide-by-zero indication; software performs those checks when it needs them.

Top module: `muldiv_unit`

## Requirements
- R1: `req_ready` is high exactly when no operation is running. A request is accepted on an edge with `req_valid` and `req_ready` high, and `busy` is high from the next cycle until the result is written.
- R2: `req_op` selects the operation: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide.
- R3: An unsigned multiply leaves the upper W bits of the 2W-bit product in HI and the lower W bits in LO.
- R4: A signed multiply leaves the two's-complement 2W-bit product of the signed operands across HI (upper) and LO (lower).
- R5: An unsigned divide with a nonzero divisor leaves the quotient in LO and the remainder in HI.
- R6: A signed divide with a nonzero divisor truncates toward zero. The remainder takes the sign of the dividend, and the quotient is negated when the operand signs differ. The most negative value divided by -1 gives the most negative value as quotient and zero as remainder.
- R7: A zero divisor completes normally with no flag. HI equals the dividend. LO is all ones, except for a signed divide with a negative dividend, where LO is +1.
- R8: `done` is high for exactly one cycle, W+1 clock cycles after the accepting edge, and HI/LO take the new result on that same edge.
- R9: A `req_valid` offered while an operation runs is ignored: the running operation is neither restarted nor altered.
- R10: Reset clears HI and LO to zero. HI and LO change only on a completion and otherwise hold their value.
- R11: A new request can be accepted in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 2 | Operation select (see R2) |
| req_a | input | W (32) | Multiplicand or dividend |
| req_b | input | W (32) | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| hi | output | W (32) | HI register: product upper half or remainder |
| lo | output | W (32) | LO register: product lower half or quotient |

## Verification
Two things can happen in the same cycle: a completion strobe and the acceptance of the next request. The bench provokes this by offering every new request in the very cycle it sees `done`. It checks that the finished result is still on HI/LO then, and that the new operation finishes with the correct value and latency. A second overlap is a request offered mid-run. It is injected during many operations, and the bench judges it by an unchanged latency and an unchanged result for the running operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } md_state_e;

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         is_div,
  output logic         neg_main,
  output logic         neg_rem
);
  md_op_e opc;
  logic   sgn;

  always_comb begin
    opc      = md_op_e'(op);
    sgn      = (opc == OP_MULS) || (opc == OP_DIVS);
    is_div   = (opc == OP_DIVS) || (opc == OP_DIVU);
    mag_a    = (sgn && a[W-1]) ? (~a + 1'b1) : a;
    mag_b    = (sgn && b[W-1]) ? (~b + 1'b1) : b;
    neg_main = sgn && (a[W-1] ^ b[W-1]);
    neg_rem  = sgn && is_div && a[W-1];
  end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic ready,
  output logic load,
  output logic step,
  output logic wr,
  output logic busy
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  md_state_e st;
  logic [CW-1:0] cnt;

  always_comb begin
    ready = (st == ST_IDLE);
    load  = ready && req_valid;
    step  = (st == ST_RUN);
    wr    = (st == ST_FIX);
    busy  = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (load) begin
          st  <= ST_RUN;
          cnt <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= ST_FIX;
        end
        ST_FIX:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         div_in,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic [W-1:0] upper,
  output logic [W-1:0] lower,
  output logic         div_q
);
  logic [W-1:0] opnd;
  logic [W:0]   mul_sum;
  logic [W:0]   rem_sh;
  logic [W:0]   diff;
  logic         fits;

  always_comb begin
    mul_sum = {1'b0, upper} + (lower[0] ? {1'b0, opnd} : '0);
    rem_sh  = {upper, lower[W-1]};
    diff    = rem_sh - {1'b0, opnd};
    fits    = !diff[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper <= '0;
      lower <= '0;
      opnd  <= '0;
      div_q <= 1'b0;
    end else if (load) begin
      upper <= '0;
      lower <= mag_a;
      opnd  <= mag_b;
      div_q <= div_in;
    end else if (step) begin
      if (div_q) begin
        upper <= fits ? diff[W-1:0] : rem_sh[W-1:0];
        lower <= {lower[W-2:0], fits};
      end else begin
        upper <= mul_sum[W:1];
        lower <= {mul_sum[0], lower[W-1:1]};
      end
    end
  end
endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         neg_main,
  input  logic         neg_rem,
  input  logic [W-1:0] upper,
  input  logic [W-1:0] lower,
  output logic [W-1:0] hi_n,
  output logic [W-1:0] lo_n
);
  logic [2*W-1:0] prod;
  logic [2*W-1:0] prod_s;

  always_comb begin
    prod   = {upper, lower};
    prod_s = neg_main ? (~prod + 1'b1) : prod;
    if (is_div) begin
      lo_n = neg_main ? (~lower + 1'b1) : lower;
      hi_n = neg_rem  ? (~upper + 1'b1) : upper;
    end else begin
      hi_n = prod_s[2*W-1:W];
      lo_n = prod_s[W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic [W-1:0] mag_a, mag_b, upper, lower, hi_n, lo_n;
  logic is_div_c, neg_main_c, neg_rem_c;
  logic neg_main_q, neg_rem_q, div_q;
  logic load, step, wr;

  muldiv_prep #(.W(W)) u_prep (
    .op(req_op), .a(req_a), .b(req_b),
    .mag_a(mag_a), .mag_b(mag_b),
    .is_div(is_div_c), .neg_main(neg_main_c), .neg_rem(neg_rem_c)
  );

  muldiv_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .ready(req_ready), .load(load), .step(step), .wr(wr), .busy(busy)
  );

  muldiv_iter #(.W(W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .div_in(is_div_c), .mag_a(mag_a), .mag_b(mag_b),
    .upper(upper), .lower(lower), .div_q(div_q)
  );

  muldiv_fix #(.W(W)) u_fix (
    .is_div(div_q), .neg_main(neg_main_q), .neg_rem(neg_rem_q),
    .upper(upper), .lower(lower), .hi_n(hi_n), .lo_n(lo_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
    end else if (load) begin
      neg_main_q <= neg_main_c;
      neg_rem_q  <= neg_rem_c;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi   <= '0;
      lo   <= '0;
      done <= 1'b0;
    end else begin
      done <= wr;
      if (wr) begin
        hi <= hi_n;
        lo <= lo_n;
      end
    end
  end
endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [1:0]   req_op,
  input logic [W-1:0] req_a,
  input logic [W-1:0] req_b,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int YW = $clog2(W + 3) + 1;
  localparam logic [YW-1:0] LAT = YW'(W + 1);

  logic [YW-1:0] cyc;
  logic          cap_divu;
  logic [W-1:0]  cap_a, cap_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc      <= '1;
      cap_divu <= 1'b0;
      cap_a    <= '0;
      cap_b    <= '0;
    end else if (req_valid && req_ready) begin
      cyc      <= '0;
      cap_divu <= (req_op == 2'b11);
      cap_a    <= req_a;
      cap_b    <= req_b;
    end else if (cyc != '1) begin
      cyc <= cyc + 1'b1;
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  assert_divzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_divu && cap_b == '0) |-> (lo == '1 && hi == cap_a));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == LAT));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hi != $past(hi) || lo != $past(lo)) |-> done);

  assert_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind muldiv_unit muldiv_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy),
  .done(done), .hi(hi), .lo(lo)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = '0;
  logic [W-1:0] req_a = '0;
  logic [W-1:0] req_b = '0;
  logic         busy, done;
  logic [W-1:0] hi, lo;

  int n_cmp = 0;
  int n_bad = 0;
  int prev_hi = 0;
  int prev_lo = 0;

  always #10 clk = ~clk;

  muldiv_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy),
    .done(done), .hi(hi), .lo(lo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v & (1 << (W - 1))) ? v - (1 << W) : v;
  endfunction

  // R2 encodings: 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div
  task automatic expect_res(input int op, input int a, input int b,
                            output int eh, output int el, output string tag);
    int sa, sb, p, q, r;
    sa = sx(a);
    sb = sx(b);
    case (op)
      0: begin p = sa * sb; eh = (p >>> W) & MASK; el = p & MASK; tag = "R4"; end
      1: begin p = a * b;   eh = (p >>  W) & MASK; el = p & MASK; tag = "R3"; end
      2: begin
        if (b == 0) begin r = sa; q = (sa < 0) ? 1 : -1; tag = "R7"; end
        else begin q = sa / sb; r = sa % sb; tag = "R6"; end
        eh = r & MASK; el = q & MASK;
      end
      default: begin
        if (b == 0) begin q = MASK; r = a; tag = "R7"; end
        else begin q = a / b; r = a % b; tag = "R5"; end
        eh = r & MASK; el = q & MASK;
      end
    endcase
  endtask

  // Called at a negedge where the unit is idle (possibly the done cycle, R11).
  task automatic run_op(input int op, input int a, input int b, input bit inject);
    int eh, el, k;
    string tag;
    expect_res(op, a, b, eh, el, tag);
    chk("R1 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_op = op[1:0];
    req_a = a[W-1:0];
    req_b = b[W-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!done && k < 40) begin
      if (k == 2) begin
        chk("R1 busy and not ready", int'({busy, req_ready}), 2);
        chk("R10 hi held during run", int'(hi), prev_hi);
        chk("R10 lo held during run", int'(lo), prev_lo);
        if (inject) begin
          req_valid = 1'b1;
          req_op = ~op[1:0];
          req_a = a[W-1:0] ^ 4'h5;
          req_b = b[W-1:0] ^ 4'h3;
        end
      end
      if (k == 3) req_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(inject ? "R9 latency with ignored request" : "R8 latency", k, W + 2);
    chk({tag, " hi"}, int'(hi), eh);
    chk({tag, " lo"}, int'(lo), el);
    prev_hi = eh;
    prev_lo = el;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset hi", int'(hi), 0);
    chk("R10 reset lo", int'(lo), 0);
    chk("R8 no done after reset", int'(done), 0);
    chk("R1 ready after reset", int'(req_ready), 1);
    for (int op = 0; op < 4; op++)
      for (int a = 0; a <= MASK; a++)
        for (int b = 0; b <= MASK; b++)
          run_op(op, a, b, ((a + b + op) % 5) == 0);
    // explicit corner: most negative divided by -1 (R6)
    run_op(2, 8, 15, 1'b0);
    chk("R6 min/-1 quotient", int'(lo), 8);
    // explicit zero divisor, signed negative dividend (R7)
    run_op(2, 12, 0, 1'b1);
    chk("R7 signed neg / 0 quotient", int'(lo), 1);
    @(negedge clk);
    chk("R8 done single cycle", int'(done), 0);
    chk("R10 hi held after done", int'(hi), prev_hi);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule